// File: doc/BRIEF.md
# Half-Rate Complex QPSK Decision Feedback Equalizer

This block makes QPSK symbol decisions on quantized baseband samples and removes inter-symbol interference with a five-tap complex decision feedback equalizer. Each clock carries two symbols on two lanes. The even lane holds the earlier symbol and the odd lane holds the later one. Each lane has an I and a Q sample. The block returns one hard decision per lane and channel.

Taps two to five use the four most recent confirmed decisions in the interleaved symbol stream. Each tap has a same-channel weight and a cross-channel weight for each channel, and the weighted signs are subtracted from the incoming sample. The first tap is not fed back. It is speculated instead. Every lane and channel compares its equalized sample against four signed thresholds, one for each possible previous QPSK symbol, which gives sixteen comparators in total. The previous symbol's decision then picks one of the four results. The even lane uses the odd decision registered in the previous cycle. The odd lane uses the even decision made in the same cycle. Each threshold also carries the DC offset correction of its comparator.

A single write port loads the weights and thresholds.

Top module: `qpsk_dfe_hr`

## Requirements
- R1: A decision bit is 1 (symbol +1) when the saturated, equalized sample is strictly greater than the threshold selected for it, and 0 (symbol -1) otherwise. A sample equal to its threshold gives 0.
- R2: In each cycle the even-lane sample is the earlier symbol and the odd-lane sample is the later one. The four decisions for the samples present at a rising edge appear on the outputs right after that edge and hold for one cycle.
- R3: Each lane and channel has four thresholds indexed by the previous symbol code 2*I+Q (decision bits). The even lane takes its index from the previous cycle's odd-lane decision. The odd lane takes its index from the same cycle's even-lane decision.
- R4: Tap k (2 to 5) subtracts w*s, where s is +1 or -1 from the k-th earlier decision in the interleaved stream. Each channel has one same-channel term and one cross-channel term per tap. Path codes are: 0 = I from I, 1 = I from Q, 2 = Q from I, 3 = Q from Q.
- R5: The equalized sample is clamped to the range -128 to 127 before it is compared, so large feedback cannot wrap.
- R6: Write address bit 4 = 0 selects a weight: bits 3:2 = tap-2, bits 1:0 = path code, data bits 5:0 = signed value. Bit 4 = 1 selects a threshold: bit 3 = lane (0 even), bit 2 = channel (0 I), bits 1:0 = index, data = signed 8-bit value. A write takes effect from the next edge. Samples taken in the write cycle use the old value.
- R7: An active-low asynchronous reset sets the decision history to +1, so all outputs read 1. It also clears every weight and threshold to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 8 | Even-lane I sample, signed |
| ev_q | input | 8 | Even-lane Q sample, signed |
| od_i | input | 8 | Odd-lane I sample, signed |
| od_q | input | 8 | Odd-lane Q sample, signed |
| wr_en | input | 1 | Write strobe for weights and thresholds |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| dec_ev_i | output | 1 | Even-lane I decision |
| dec_ev_q | output | 1 | Even-lane Q decision |
| dec_od_i | output | 1 | Odd-lane I decision |
| dec_od_q | output | 1 | Odd-lane Q decision |

## Verification
With all weights and thresholds at zero, the sign patterns separate lane and channel swaps and cover the exact-zero boundary. Sixteen distinct thresholds with mid-range samples show which previous symbol each lane uses to select, so a wrong-lane or stale-cycle select shows up at once. Distinct non-zero weights on every tap and path under pseudo-random samples catch swapped taps, swapped same- and cross-channel terms, and history misalignment. The saturation pattern uses thresholds at which a wrapped sum and a clamped sum give opposite decisions. Writes placed in the same cycle as discriminating samples show when a new value takes effect.

// File: rtl/qdfe_pkg.sv
package qdfe_pkg;
   // one QPSK symbol decision: [1] = I, [0] = Q, 1 means +1
   typedef logic [1:0] sym_t;
   // speculative comparators per lane and channel
   localparam int NSPEC = 4;
   // weight path codes
   localparam int PATH_II = 0;
   localparam int PATH_IQ = 1;
   localparam int PATH_QI = 2;
   localparam int PATH_QQ = 3;
endpackage

// File: rtl/qdfe_regs.sv
module qdfe_regs
   import qdfe_pkg::*;
#(
   parameter int NPOST = 4,
   parameter int CW    = 6,
   parameter int TW    = 8,
   parameter int CIW   = 2,
   parameter int AW    = 5,
   parameter int DW    = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [NPOST-1:0][3:0][CW-1:0] coef,
   output logic [1:0][1:0][NSPEC-1:0][TW-1:0] thr
);
   if (AW < 5 || CIW + 2 > AW - 1) begin : g_bad_aw
      $error("qdfe_regs: address too narrow");
   end

   logic [CIW-1:0] tap_idx;
   assign tap_idx = wr_addr[CIW+1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef <= '0;
         thr  <= '0;
      end else if (wr_en) begin
         if (!wr_addr[AW-1]) begin
            if (int'(tap_idx) < NPOST)
               coef[tap_idx][wr_addr[1:0]] <= wr_data[CW-1:0];
         end else begin
            thr[wr_addr[3]][wr_addr[2]][wr_addr[1:0]] <= wr_data[TW-1:0];
         end
      end
   end

   // checker state: last write seen at the port
   logic          chk_we;
   logic [AW-1:0] chk_a;
   logic [DW-1:0] chk_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_we <= 1'b0;
         chk_a  <= '0;
         chk_d  <= '0;
      end else begin
         chk_we <= wr_en;
         chk_a  <= wr_addr;
         chk_d  <= wr_data;
      end
   end

   a_r6_wr_coef: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_we && !chk_a[AW-1] && (int'(chk_a[CIW+1:2]) < NPOST))
         |-> (coef[chk_a[CIW+1:2]][chk_a[1:0]] == chk_d[CW-1:0]));

   a_r6_wr_thr: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_we && chk_a[AW-1])
         |-> (thr[chk_a[3]][chk_a[2]][chk_a[1:0]] == chk_d[TW-1:0]));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(coef) && $stable(thr)));
endmodule

// File: rtl/qdfe_lane.sv
module qdfe_lane
   import qdfe_pkg::*;
#(
   parameter int NPOST = 4,
   parameter int XW    = 8,
   parameter int CW    = 6,
   parameter int TW    = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic [XW-1:0] x_i,
   input  logic [XW-1:0] x_q,
   input  sym_t [NPOST-1:0] post,
   input  logic [NPOST-1:0][3:0][CW-1:0] coef,
   input  logic [1:0][NSPEC-1:0][TW-1:0] thr_l,
   input  sym_t sel,
   output sym_t dec
);
   localparam int SW   = XW + CW + $clog2(2 * NPOST) + 1;
   localparam int MAXV = 2 ** (XW - 1) - 1;
   localparam int MINV = -(2 ** (XW - 1));

   if (TW > SW) begin : g_bad_tw
      $error("qdfe_lane: threshold wider than sum path");
   end

   logic [1:0] dch;   // index 0 = I channel, 1 = Q channel

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      logic signed [SW-1:0] fb;
      logic signed [SW-1:0] wide;
      logic signed [XW-1:0] y;
      logic [XW-1:0]        xin;
      logic [NSPEC-1:0]     spec;

      assign xin = (ch == 0) ? x_i : x_q;

      // taps 2..N: +w for a +1 decision, -w for a -1 decision
      always_comb begin
         fb = '0;
         for (int t = 0; t < NPOST; t++) begin
            if (post[t][1]) fb = fb + SW'($signed(coef[t][2*ch]));
            else            fb = fb - SW'($signed(coef[t][2*ch]));
            if (post[t][0]) fb = fb + SW'($signed(coef[t][2*ch+1]));
            else            fb = fb - SW'($signed(coef[t][2*ch+1]));
         end
      end

      assign wide = SW'($signed(xin)) - fb;

      always_comb begin
         if (wide > SW'(MAXV))      y = XW'(MAXV);
         else if (wide < SW'(MINV)) y = XW'(MINV);
         else                       y = wide[XW-1:0];
      end

      // unrolled first tap: one comparator per possible previous symbol
      for (genvar s = 0; s < NSPEC; s++) begin : g_spec
         assign spec[s] = SW'(y) > SW'($signed(thr_l[ch][s]));
      end

      assign dch[ch] = spec[sel];

      a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
         wide[SW-1] == y[XW-1]);
   end

   assign dec = {dch[0], dch[1]};
endmodule

// File: rtl/qpsk_dfe_hr.sv
module qpsk_dfe_hr
   import qdfe_pkg::*;
#(
   parameter  int NTAPS = 5,
   parameter  int XW    = 8,
   parameter  int CW    = 6,
   parameter  int TW    = 8,
   localparam int NPOST = NTAPS - 1,
   localparam int CIW   = $clog2(NPOST),
   localparam int AW    = (((CIW + 2) > 4) ? (CIW + 2) : 4) + 1,
   localparam int DW    = (CW > TW) ? CW : TW
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] ev_i,
   input  logic [XW-1:0] ev_q,
   input  logic [XW-1:0] od_i,
   input  logic [XW-1:0] od_q,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          dec_ev_i,
   output logic          dec_ev_q,
   output logic          dec_od_i,
   output logic          dec_od_q
);
   if (NTAPS < 3) begin : g_bad_taps
      $error("qpsk_dfe_hr: NTAPS must be at least 3");
   end
   if (XW < 2 || CW < 2 || TW < 2) begin : g_bad_w
      $error("qpsk_dfe_hr: widths must be at least 2");
   end

   logic [NPOST-1:0][3:0][CW-1:0]     coef;
   logic [1:0][1:0][NSPEC-1:0][TW-1:0] thr;

   // hist[0] = latest odd decision, hist[1] = latest even, then older
   sym_t [NTAPS-1:0] hist;
   sym_t ev_dec;
   sym_t od_dec;

   qdfe_regs #(
      .NPOST(NPOST), .CW(CW), .TW(TW), .CIW(CIW), .AW(AW), .DW(DW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .coef(coef), .thr(thr)
   );

   qdfe_lane #(.NPOST(NPOST), .XW(XW), .CW(CW), .TW(TW)) u_ev (
      .clk(clk), .rst_n(rst_n), .x_i(ev_i), .x_q(ev_q),
      .post(hist[NTAPS-1:1]), .coef(coef), .thr_l(thr[0]),
      .sel(hist[0]), .dec(ev_dec)
   );

   qdfe_lane #(.NPOST(NPOST), .XW(XW), .CW(CW), .TW(TW)) u_od (
      .clk(clk), .rst_n(rst_n), .x_i(od_i), .x_q(od_q),
      .post(hist[NTAPS-2:0]), .coef(coef), .thr_l(thr[1]),
      .sel(ev_dec), .dec(od_dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '1;
      end else begin
         hist[0] <= od_dec;
         hist[1] <= ev_dec;
         for (int k = 2; k < NTAPS; k++) hist[k] <= hist[k-2];
      end
   end

   assign dec_ev_i = hist[1][1];
   assign dec_ev_q = hist[1][0];
   assign dec_od_i = hist[0][1];
   assign dec_od_q = hist[0][0];

   a_r7_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ({dec_ev_i, dec_ev_q, dec_od_i, dec_od_q} == 4'b1111));

   a_r2_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({dec_ev_i, dec_ev_q, dec_od_i, dec_od_q}));
endmodule

// File: tb/qpsk_dfe_hr_tb.sv
module qpsk_dfe_hr_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ev_i = '0, ev_q = '0, od_i = '0, od_q = '0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       dec_ev_i, dec_ev_q, dec_od_i, dec_od_q;

   int n_tot = 0;
   int n_bad = 0;

   // reference model state
   int         mc [4][4];
   int         mt [2][2][4];
   logic [1:0] mh [5];
   logic [31:0] lf = 32'h1234_5678;

   always #(CLK_P/2) clk = ~clk;

   qpsk_dfe_hr u_dut (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ev_q(ev_q), .od_i(od_i),
      .od_q(od_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dec_ev_i(dec_ev_i), .dec_ev_q(dec_ev_q), .dec_od_i(dec_od_i),
      .dec_od_q(dec_od_q)
   );

   task automatic model_reset();
      for (int t = 0; t < 4; t++) for (int p = 0; p < 4; p++) mc[t][p] = 0;
      for (int l = 0; l < 2; l++) for (int c = 0; c < 2; c++)
         for (int s = 0; s < 4; s++) mt[l][c][s] = 0;
      for (int k = 0; k < 5; k++) mh[k] = 2'b11;
   endtask

   task automatic model_wr(input int wa, input int wd);
      int v;
      if (wa < 16) begin
         v = wd & 63; if (v >= 32) v = v - 64;
         mc[wa/4][wa%4] = v;
      end else begin
         v = wd & 255; if (v >= 128) v = v - 256;
         mt[(wa/8)%2][(wa/4)%2][wa%4] = v;
      end
   endtask

   function automatic logic [1:0] ref_lane(input int lane, input int xi,
                                           input int xq, input logic [1:0] sel);
      logic [1:0] r;
      logic [1:0] d;
      int fb;
      int y;
      r = 2'b00;
      for (int ch = 0; ch < 2; ch++) begin
         fb = 0;
         for (int t = 0; t < 4; t++) begin
            d = mh[t + 1 - lane];
            fb = fb + (d[1] ? 1 : -1) * mc[t][2*ch];
            fb = fb + (d[0] ? 1 : -1) * mc[t][2*ch+1];
         end
         y = ((ch == 0) ? xi : xq) - fb;
         if (y > 127) y = 127;
         if (y < -128) y = -128;
         r[1-ch] = (y > mt[lane][ch][sel]);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {ev_i,ev_q,od_i,od_q} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // called right after a falling edge; returns right after the next one
   task automatic step(input int ei, input int eq, input int oi, input int oq,
                       input string req, input bit we = 1'b0,
                       input int wa = 0, input int wd = 0);
      logic [1:0] e;
      logic [1:0] o;
      ev_i = 8'(ei); ev_q = 8'(eq); od_i = 8'(oi); od_q = 8'(oq);
      wr_en = we; wr_addr = 5'(wa); wr_data = 8'(wd);
      e = ref_lane(0, ei, eq, mh[0]);
      o = ref_lane(1, oi, oq, e);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      chk(req, {dec_ev_i, dec_ev_q, dec_od_i, dec_od_q}, {e, o});
      for (int k = 4; k >= 2; k--) mh[k] = mh[k-2];
      mh[1] = e;
      mh[0] = o;
      if (we) model_wr(wa, wd);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   function automatic int rnd8();
      lf = lf * 32'd1664525 + 32'd1013904223;
      return int'($signed(lf[23:16]));
   endfunction

   task automatic t_reset();
      do_reset();
      chk("R7 reset outputs", {dec_ev_i, dec_ev_q, dec_od_i, dec_od_q}, 4'b1111);
   endtask

   task automatic t_sign();
      step(5, -5, 1, 0, "R1 R2 sign lanes");
      step(0, -1, 127, -128, "R1 zero boundary");
      step(-128, 127, -3, 3, "R2 lane order");
      step(1, 1, -1, -1, "R1 R2 unit");
      step(0, 0, 0, 0, "R1 all zero");
   endtask

   task automatic t_spec();
      for (int i = 0; i < 16; i++)
         step(0, 0, 0, 0, "R3 thr load", 1'b1, 16 + i, -90 + 12 * i);
      for (int n = 0; n < 40; n++)
         step(rnd8() % 101, rnd8() % 101, rnd8() % 101, rnd8() % 101,
              "R3 speculative select");
   endtask

   task automatic t_post();
      for (int i = 0; i < 16; i++)
         step(rnd8(), rnd8(), rnd8(), rnd8(), "R4 weight load", 1'b1, i,
              ((i * 7) % 63) - 31);
      for (int n = 0; n < 60; n++)
         step(rnd8(), rnd8(), rnd8(), rnd8(), "R4 feedback taps");
   endtask

   task automatic t_sat();
      for (int i = 0; i < 16; i++) step(127, 127, 127, 127, "R5 load", 1'b1, i, 31);
      for (int i = 0; i < 16; i++) step(127, 127, 127, 127, "R5 load", 1'b1, 16 + i, -125);
      for (int n = 0; n < 3; n++) step(127, 127, 127, 127, "R5 hold +1");
      // clamped -128 is not above -125; a wrapped sum would be
      step(-128, -128, -128, -128, "R5 low clamp");
      step(-128, -128, -128, -128, "R5 low clamp again");
      for (int i = 0; i < 16; i++) step(-128, -128, -128, -128, "R5 load", 1'b1, i, -32);
      step(127, 127, 127, 127, "R5 high clamp");
      step(127, -128, -128, 127, "R5 mixed clamp");
   endtask

   task automatic t_reset_mid();
      do_reset();
      chk("R7 reset mid-run", {dec_ev_i, dec_ev_q, dec_od_i, dec_od_q}, 4'b1111);
      step(3, -3, -7, 7, "R7 weights cleared");
      step(0, 1, 1, 0, "R7 thresholds cleared");
   endtask

   task automatic t_wrtime();
      step(10, 10, 10, 10, "R6 prime");
      step(10, 10, 10, 10, "R6 weight write cycle", 1'b1, 0, -31);
      step(-20, 5, 5, 5, "R6 weight active");
      step(5, 5, 5, 5, "R6 prime 2");
      step(5, 5, 5, 5, "R6 thr write cycle", 1'b1, 19, 50);
      step(5, 5, 5, 5, "R6 thr active");
   endtask

   initial begin
      #(CLK_P * 150000);
      n_tot++;
      n_bad++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      t_reset();
      t_sign();
      t_spec();
      t_post();
      t_sat();
      t_reset_mid();
      t_wrtime();
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end
endmodule